// File: doc/BRIEF.md
# Indexed Address Modifier With Bank Steering

The block forms the effective address of an operand. It adds the contents of one of six index registers to the execution address field of the current instruction. An index select of zero leaves the field unmodified. Each index register can be loaded, incremented or decremented once per loop pass. A one-cycle exit flag reports when a counting-up register reaches a supplied threshold, or when a counting-down register reaches zero.

The address is 15 bits wide. Its low bit picks one of two interleaved 16K-word banks, even or odd, and the upper 14 bits are the word address inside that bank. Each bank has its own storage address register. On a request, the register of the addressed bank captures the in-bank address and the other bank's register holds its value. On an instruction fetch the address comes from the program counter input. On an operand access it comes from the index adder. The memory arrays themselves sit outside this block.

Top module: `idx_addr_mod`

## Requirements
- R1: While and after reset, req_o, exit_o, bank_o, bank_addr_o and both storage address registers are 0, and all six index registers hold 0.
- R2: With fetch_i=0 and idx_sel_i in 1..6, the effective address is (exec_addr_i + index[idx_sel_i]) mod 2^15. The index value used is the one held before any update applied in the same cycle.
- R3: With idx_sel_i equal to 0 or 7, the effective address equals exec_addr_i unchanged.
- R4: With fetch_i=1, the address is pc_i, and the index select has no effect on it.
- R5: One clock after req_i=1, req_o=1, bank_o equals address bit 0 (0 even, 1 odd), and bank_addr_o equals address bits 14:1. One clock after req_i=0, req_o=0.
- R6: On a request, only the storage address register of the addressed bank (sar_even_o or sar_odd_o) loads bank_addr; the other holds. Without a request, both hold.
- R7: upd_op_i encodes 0 hold, 1 load upd_data_i, 2 increment, 3 decrement, applied to index[upd_sel_i] at the clock edge. Increment and decrement wrap modulo 2^15.
- R8: exit_o is 1 in the cycle after an increment whose result equals thresh_i. This includes a wrap from 0x7FFF to 0 when thresh_i is 0.
- R9: exit_o is 1 in the cycle after a decrement whose result is 0. A decrement from 0 wraps to 0x7FFF and does not raise exit_o. Hold, load and all other cycles give exit_o=0.
- R10: With upd_sel_i equal to 0 or 7, no index register changes, whatever upd_op_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Memory access request this cycle |
| fetch_i | input | 1 | 1: instruction fetch from pc_i, 0: operand access |
| pc_i | input | 15 | Program counter address |
| exec_addr_i | input | 15 | Execution address field of the instruction |
| idx_sel_i | input | 3 | Index register used for modification (0 = none) |
| upd_sel_i | input | 3 | Index register to update (0 = none) |
| upd_op_i | input | 2 | Update: 0 hold, 1 load, 2 increment, 3 decrement |
| upd_data_i | input | 15 | Load value |
| thresh_i | input | 15 | Exit threshold for counting up |
| req_o | output | 1 | Registered request strobe |
| bank_o | output | 1 | Bank select, 0 even, 1 odd |
| bank_addr_o | output | 14 | In-bank word address |
| sar_even_o | output | 14 | Even bank storage address register |
| sar_odd_o | output | 14 | Odd bank storage address register |
| exit_o | output | 1 | Loop exit flag |

## Verification
Every result of this block is due exactly one clock after its stimulus. req_o, bank_o, bank_addr_o and the storage address registers change at the edge that samples req_i. exit_o and a new index value appear at the edge that samples the update command. An index update becomes visible in an address only on a request made in a later cycle. The bench therefore drives each stimulus at a falling edge and lets one rising edge pass. It samples at the next falling edge against a model that it updates at the same point. Index contents are read back through requests with a zero execution address.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_INC  = 2'd2,
    UPD_DEC  = 2'd3
  } upd_op_e;
endpackage

// File: rtl/idx_regfile.sv
module idx_regfile
  import idx_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int NUM_IDX = 6,
  parameter int SEL_W   = $clog2(NUM_IDX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  rd_sel_i,
  input  logic [SEL_W-1:0]  upd_sel_i,
  input  upd_op_e           upd_op_i,
  input  logic [ADDR_W-1:0] upd_data_i,
  input  logic [ADDR_W-1:0] thresh_i,
  output logic [ADDR_W-1:0] rd_val_o,
  output logic              rd_hit_o,
  output logic              exit_o
);
  logic [ADDR_W-1:0] idx_q [NUM_IDX];
  logic [ADDR_W-1:0] upd_cur, upd_nxt;
  logic              upd_hit, exit_d, exit_q;

  always_comb begin
    rd_val_o = '0;
    rd_hit_o = 1'b0;
    upd_cur  = '0;
    upd_hit  = 1'b0;
    for (int i = 0; i < NUM_IDX; i++) begin
      if (rd_sel_i == SEL_W'(i + 1)) begin
        rd_val_o = idx_q[i];
        rd_hit_o = 1'b1;
      end
      if (upd_sel_i == SEL_W'(i + 1)) begin
        upd_cur = idx_q[i];
        upd_hit = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (upd_op_i)
      UPD_LOAD: upd_nxt = upd_data_i;
      UPD_INC:  upd_nxt = upd_cur + ADDR_W'(1);
      UPD_DEC:  upd_nxt = upd_cur - ADDR_W'(1);
      default:  upd_nxt = upd_cur;
    endcase
  end

  // exit: count-up reaches threshold, count-down reaches zero
  assign exit_d = upd_hit &&
                  ((upd_op_i == UPD_INC && upd_nxt == thresh_i) ||
                   (upd_op_i == UPD_DEC && upd_nxt == '0));

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                                      idx_q[g] <= '0;
      else if (upd_sel_i == SEL_W'(g + 1) && upd_op_i != UPD_HOLD) idx_q[g] <= upd_nxt;
    end

    a_r7_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_sel_i == SEL_W'(g + 1) && upd_op_i == UPD_INC)
        |=> idx_q[g] == ADDR_W'($past(idx_q[g]) + 1'b1));

    a_r7_dec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_sel_i == SEL_W'(g + 1) && upd_op_i == UPD_DEC)
        |=> idx_q[g] == ADDR_W'($past(idx_q[g]) - 1'b1));

    a_r10_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_sel_i != SEL_W'(g + 1)) |=> $stable(idx_q[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exit_q <= 1'b0;
    else         exit_q <= exit_d;
  end
  assign exit_o = exit_q;

  a_r9_dec_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_hit && upd_op_i == UPD_DEC && upd_cur == ADDR_W'(1)) |=> exit_o);

  a_r9_exit_needs_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == UPD_HOLD || upd_op_i == UPD_LOAD || !upd_hit) |=> !exit_o);

  a_r8_inc_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_hit && upd_op_i == UPD_INC && upd_cur == thresh_i - ADDR_W'(1)) |=> exit_o);
endmodule

// File: rtl/idx_ea_adder.sv
module idx_ea_adder #(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] exec_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic              hit_i,
  output logic [ADDR_W-1:0] eff_o
);
  logic [ADDR_W-1:0] ofs;

  assign ofs   = hit_i ? idx_i : '0;
  assign eff_o = exec_i + ofs;  // wraps modulo 2^ADDR_W

  always_comb begin
    if (!hit_i) a_r3_passthru: assert (eff_o == exec_i);
  end
endmodule

// File: rtl/idx_bank_steer.sv
module idx_bank_steer #(
  parameter int ADDR_W  = 15,
  parameter int BANK_AW = ADDR_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               req_o,
  output logic               bank_o,
  output logic [BANK_AW-1:0] bank_addr_o,
  output logic [BANK_AW-1:0] sar_even_o,
  output logic [BANK_AW-1:0] sar_odd_o
);
  logic [BANK_AW-1:0] sar_q [2];
  logic               req_q, bank_q;
  logic [BANK_AW-1:0] word_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           sar_q[b] <= '0;
      else if (req_i && addr_i[0] == 1'(b)) sar_q[b] <= addr_i[ADDR_W-1:1];
    end

    a_r6_other_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req_i || addr_i[0] != 1'(b)) |=> $stable(sar_q[b]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      bank_q <= 1'b0;
      word_q <= '0;
    end else begin
      req_q <= req_i;
      if (req_i) begin
        bank_q <= addr_i[0];
        word_q <= addr_i[ADDR_W-1:1];
      end
    end
  end

  assign req_o       = req_q;
  assign bank_o      = bank_q;
  assign bank_addr_o = word_q;
  assign sar_even_o  = sar_q[0];
  assign sar_odd_o   = sar_q[1];

  a_r5_req_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> req_o);
  a_r5_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !req_o);
  a_r6_sar_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (bank_o ? sar_odd_o : sar_even_o) == bank_addr_o);
endmodule

// File: rtl/idx_addr_mod.sv
module idx_addr_mod
  import idx_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int NUM_IDX = 6,
  parameter int SEL_W   = $clog2(NUM_IDX + 1),
  parameter int BANK_AW = ADDR_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               fetch_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [ADDR_W-1:0]  exec_addr_i,
  input  logic [SEL_W-1:0]   idx_sel_i,
  input  logic [SEL_W-1:0]   upd_sel_i,
  input  logic [1:0]         upd_op_i,
  input  logic [ADDR_W-1:0]  upd_data_i,
  input  logic [ADDR_W-1:0]  thresh_i,
  output logic               req_o,
  output logic               bank_o,
  output logic [BANK_AW-1:0] bank_addr_o,
  output logic [BANK_AW-1:0] sar_even_o,
  output logic [BANK_AW-1:0] sar_odd_o,
  output logic               exit_o
);
  logic [ADDR_W-1:0] idx_val, eff_addr, mem_addr;
  logic              idx_hit;

  idx_regfile #(.ADDR_W(ADDR_W), .NUM_IDX(NUM_IDX), .SEL_W(SEL_W)) u_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_sel_i   (idx_sel_i),
    .upd_sel_i  (upd_sel_i),
    .upd_op_i   (upd_op_e'(upd_op_i)),
    .upd_data_i (upd_data_i),
    .thresh_i   (thresh_i),
    .rd_val_o   (idx_val),
    .rd_hit_o   (idx_hit),
    .exit_o     (exit_o)
  );

  idx_ea_adder #(.ADDR_W(ADDR_W)) u_adder (
    .exec_i (exec_addr_i),
    .idx_i  (idx_val),
    .hit_i  (idx_hit),
    .eff_o  (eff_addr)
  );

  // fetch takes the program counter, operands take the modified address
  assign mem_addr = fetch_i ? pc_i : eff_addr;

  idx_bank_steer #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW)) u_steer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .addr_i      (mem_addr),
    .req_o       (req_o),
    .bank_o      (bank_o),
    .bank_addr_o (bank_addr_o),
    .sar_even_o  (sar_even_o),
    .sar_odd_o   (sar_odd_o)
  );

  a_r4_fetch_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && fetch_i) |=> {bank_addr_o, bank_o} == $past(pc_i));
  a_r3_no_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !fetch_i && (idx_sel_i == '0 || idx_sel_i > SEL_W'(NUM_IDX)))
      |=> {bank_addr_o, bank_o} == $past(exec_addr_i));
endmodule

// File: tb/idx_addr_mod_bench.sv
`timescale 1ns/1ps
module idx_addr_mod_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, fetch = 1'b0;
  logic [AW-1:0] pc = '0, exec = '0, udata = '0, thr = '0;
  logic [2:0]    isel = '0, usel = '0;
  logic [1:0]    uop = '0;
  logic          req_o, bank_o, exit_o;
  logic [13:0]   bank_addr_o, sar_e, sar_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [AW-1:0] m_idx [1:6];
  logic [13:0]   m_sar_e = '0, m_sar_o = '0;
  logic [AW-1:0] e_addr;
  logic          e_exit;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_addr_mod u_idx_addr_mod (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .fetch_i(fetch), .pc_i(pc),
    .exec_addr_i(exec), .idx_sel_i(isel), .upd_sel_i(usel), .upd_op_i(uop),
    .upd_data_i(udata), .thresh_i(thr), .req_o(req_o), .bank_o(bank_o),
    .bank_addr_o(bank_addr_o), .sar_even_o(sar_e), .sar_odd_o(sar_o), .exit_o(exit_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // one cycle: drive at falling edge, model update, sample at next falling edge
  task automatic cyc(input logic r, input logic f, input logic [AW-1:0] p,
                     input logic [AW-1:0] ex, input logic [2:0] is,
                     input logic [2:0] us, input logic [1:0] op,
                     input logic [AW-1:0] d, input logic [AW-1:0] th);
    logic [AW-1:0] nv;
    req = r; fetch = f; pc = p; exec = ex; isel = is;
    usel = us; uop = op; udata = d; thr = th;
    if (f)                        e_addr = p;
    else if (is >= 1 && is <= 6) e_addr = AW'(ex + m_idx[is]);
    else                          e_addr = ex;
    if (r) begin
      if (e_addr[0]) m_sar_o = e_addr[14:1];
      else           m_sar_e = e_addr[14:1];
    end
    e_exit = 1'b0;
    if (us >= 1 && us <= 6) begin
      case (op)
        2'd1:    nv = d;
        2'd2:    nv = AW'(m_idx[us] + 1);
        2'd3:    nv = AW'(m_idx[us] - 1);
        default: nv = m_idx[us];
      endcase
      e_exit = (op == 2'd2 && nv == th) || (op == 2'd3 && nv == '0);
      m_idx[us] = nv;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_access(input string tag);
    chk({tag, " req_o"}, req_o, 1);
    chk({tag, " bank"}, bank_o, e_addr[0]);
    chk({tag, " bank_addr"}, bank_addr_o, e_addr[14:1]);
    chk({tag, " sar_even"}, sar_e, m_sar_e);
    chk({tag, " sar_odd"}, sar_o, m_sar_o);
  endtask

  initial begin
    for (int i = 1; i <= 6; i++) m_idx[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req_o", req_o, 0); chk("R1 exit", exit_o, 0);
    chk("R1 bank", bank_o, 0); chk("R1 bank_addr", bank_addr_o, 0);
    chk("R1 sar_even", sar_e, 0); chk("R1 sar_odd", sar_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 1; s <= 6; s++) begin
      cyc(1, 0, 0, 15'h0, 3'(s), 0, 0, 0, 0);
      chk_access("R1 index zero");
    end
    // R7 loads, R10 ignored selects
    for (int s = 1; s <= 6; s++) begin
      cyc(0, 0, 0, 0, 0, 3'(s), 2'd1, AW'(s * 15'h1111 + 3), 0);
      chk("R7 load no exit", exit_o, 0);
    end
    cyc(0, 0, 0, 0, 0, 3'd0, 2'd1, 15'h5555, 0);
    cyc(0, 0, 0, 0, 0, 3'd7, 2'd2, 15'h5555, 0);
    chk("R10 sel7 no exit", exit_o, 0);
    cyc(0, 0, 0, 0, 0, 3'd7, 2'd3, 0, 0);
    // R2 R3 R5 R6 sweep over selects and addresses
    for (int s = 0; s <= 7; s++) begin
      for (int e = 0; e < 6; e++) begin
        logic [AW-1:0] ea;
        ea = (e == 5) ? 15'h7FFF : AW'(e * 15'h1999 + s);
        cyc(1, 0, 0, ea, 3'(s), 0, 0, 0, 0);
        if (s == 0 || s == 7) chk_access("R3 no modification");
        else                  chk_access("R2 indexed sum");
      end
    end
    // R6 idle cycle holds both SARs, R5 req_o low
    cyc(0, 0, 0, 15'h1234, 3'd2, 0, 0, 0, 0);
    chk("R5 idle req_o", req_o, 0);
    chk("R6 idle sar_even", sar_e, m_sar_e);
    chk("R6 idle sar_odd", sar_o, m_sar_o);
    // R4 fetch ignores index
    cyc(1, 1, 15'h2AAB, 15'h0100, 3'd3, 0, 0, 0, 0);
    chk_access("R4 fetch odd");
    cyc(1, 1, 15'h1554, 15'h0100, 3'd5, 0, 0, 0, 0);
    chk_access("R4 fetch even");
    // R8 count up to threshold; address uses pre-update value (R2)
    cyc(0, 0, 0, 0, 0, 3'd2, 2'd1, 15'd5, 0);
    for (int k = 0; k < 4; k++) begin
      cyc(1, 0, 0, 15'h0040, 3'd2, 3'd2, 2'd2, 0, 15'd9);
      chk("R8 exit on threshold", exit_o, e_exit);
      chk_access("R2 same cycle update");
    end
    chk("R8 exit at 9", exit_o, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 15'd9);
    chk("R9 exit one cycle", exit_o, 0);
    // R8 wrap to zero with threshold 0
    cyc(0, 0, 0, 0, 0, 3'd6, 2'd1, 15'h7FFF, 0);
    cyc(0, 0, 0, 0, 0, 3'd6, 2'd2, 0, 15'd0);
    chk("R8 wrap exit", exit_o, 1);
    // R9 count down to zero, then wrap
    cyc(0, 0, 0, 0, 0, 3'd4, 2'd1, 15'd3, 0);
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, 0, 0, 3'd4, 2'd3, 0, 15'h7FFF);
      chk("R9 exit on zero", exit_o, e_exit);
    end
    chk("R9 exit at zero", exit_o, 1);
    cyc(0, 0, 0, 0, 0, 3'd4, 2'd3, 0, 15'h7FFF);
    chk("R9 no exit after wrap", exit_o, 0);
    cyc(1, 0, 0, 15'h0, 3'd4, 0, 0, 0, 0);
    chk("R7 dec wrap value", {bank_addr_o, bank_o}, 15'h7FFF);
    chk_access("R9 readback");
    // R7 hold op leaves value
    cyc(0, 0, 0, 0, 0, 3'd1, 2'd0, 15'h7777, 0);
    chk("R7 hold no exit", exit_o, 0);
    // R10 final readback of all registers
    for (int s = 1; s <= 6; s++) begin
      cyc(1, 0, 0, 15'h0, 3'(s), 0, 0, 0, 0);
      chk_access("R10 readback");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule